// File: doc/BRIEF.md
# I/O Port Address Router

This block sits between a CPU's I/O port cycle and three register targets. Each CPU request carries a 16-bit port address, a byte/word flag, a direction and write data. The router decides which target owns each byte of the access: the system register target, the EEPROM control target or the 8-bit cartridge bus. It drives that target over a shared request bus with one select line per target, gathers the read bytes and raises a one-cycle ready pulse when the whole access is over. Addresses that no target owns are open bus. Reads of open bus return a fixed value that depends on the display mode, and writes to open bus are dropped.

Word accesses that a target cannot take in a single phase are broken into byte phases. This covers every word access to the 8-bit cartridge bus and every unaligned word access outside the EEPROM range. A mode input hides the colour-only register ports, and a wait-state input stretches each cartridge byte phase to two cycles.

The request fields are captured when a request is accepted. The CPU holds `cpuReq` high until it sees `cpuReady`, and each target answers combinationally in the cycle its select is high.

Top module: `ioPortRouter`

## Requirements
- R1: An address in 0x00B8..0x00BF, matched on all 16 bits, goes to the EEPROM target, and this check takes priority over all others.
- R2: Failing R1, an address in 0x00C0..0x00FF, matched on all 16 bits, goes to the cartridge target.
- R3: Failing R1 and R2, an address whose bits [8:0] are at most 0x0B7 goes to the system register target, so that target repeats every 512 ports. Any other address is open bus.
- R4: While `colorMode` is 0, system-register addresses whose bits [8:0] lie in 0x040..0x06B, 0x070..0x077 or 0x09E..0x09F are open bus.
- R5: An open-bus phase lasts one cycle and raises no target select. A read returns 0x90 in each byte when `colorMode` is 0 and 0x00 when it is 1. A write is discarded.
- R6: A system-register or EEPROM phase lasts one cycle. An aligned word access to either of these targets is one phase with `tgtWord`=1.
- R7: A cartridge phase always carries one byte (`tgtWord`=0). It lasts one cycle when `cartSlow`=0 and two cycles when `cartSlow`=1.
- R8: An aligned word access to the cartridge is a low-byte phase at the address, followed at once by a high-byte phase at address+1.
- R9: An unaligned word access, other than the case in R10, is a byte phase at the address, then one idle penalty cycle, then a byte phase at address+1 (wrapping modulo 2^16). Each byte is routed by its own address.
- R10: An unaligned word access whose two bytes both fall in the EEPROM range is a single word phase at the given odd address, with no penalty cycle.
- R11: `cpuReady` is high for exactly one cycle: the cycle after the last phase or penalty cycle ends. No target select is high in that cycle. The read data is little-endian: the byte at the lower address is in bits [7:0]. A byte read returns zero in bits [15:8].
- R12: A word phase drives all of `cpuWdata` on `tgtWdata`. A byte phase drives the byte in `tgtWdata[7:0]` with zeros above it. The first byte phase carries `cpuWdata[7:0]` and the second carries `cpuWdata[15:8]`.
- R13: During reset no target select and no ready is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| colorMode | input | 1 | Colour mode enable, captured with each request |
| cartSlow | input | 1 | 1 adds a wait cycle to each cartridge byte |
| cpuReq | input | 1 | CPU request, held until ready |
| cpuAddr | input | 16 | Port address |
| cpuWord | input | 1 | 1 = word access, 0 = byte access |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuWdata | input | 16 | Write data |
| cpuRdata | output | 16 | Assembled read data, valid with ready |
| cpuReady | output | 1 | One-cycle completion pulse |
| tgtAddr | output | 16 | Target-side address of the current phase |
| tgtWdata | output | 16 | Target-side write data |
| tgtWord | output | 1 | Current phase is a word phase |
| tgtWrite | output | 1 | Current phase is a write |
| socReq | output | 1 | System register target select |
| socRdata | input | 16 | System register target read data |
| eepReq | output | 1 | EEPROM target select |
| eepRdata | input | 16 | EEPROM target read data |
| cartReq | output | 1 | Cartridge target select |
| cartRdata | input | 8 | Cartridge read data |

## Verification
The penalty cycle of an unaligned split and the cartridge wait state can fall in the same access. At 0x00BF the first byte goes to EEPROM, then the penalty cycle follows, then a cartridge byte that is stretched when `cartSlow` is 1. The alias decode and the colour gate also act on the same byte when an unaligned word starts at 0xFFFF or inside a gated window. The bench provokes these cases directly. A behavioural model lists, cycle by cycle, the target select, address, width and data expected in each cycle, and every cycle is compared against it up to and including the ready pulse.

// File: rtl/ioRoutePkg.sv
package ioRoutePkg;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 16;
  localparam int BYTE_W  = 8;
  localparam int ALIAS_W = 9;

  localparam logic [ADDR_W-1:0] EEP_FIRST  = 16'h00B8;
  localparam logic [ADDR_W-1:0] EEP_LAST   = 16'h00BF;
  localparam logic [ADDR_W-1:0] CART_FIRST = 16'h00C0;
  localparam logic [ADDR_W-1:0] CART_LAST  = 16'h00FF;
  localparam logic [ALIAS_W-1:0] SOC_LAST  = 9'h0B7;

  typedef enum logic [1:0] {
    TGT_SOC  = 2'd0,
    TGT_EEP  = 2'd1,
    TGT_CART = 2'd2,
    TGT_OPEN = 2'd3
  } tgt_e;

  typedef struct packed {
    logic latch;    // capture a new request
    logic upper;    // second byte phase in progress
    logic wide;     // current phase is a word phase
    logic capLo;    // store byte result in low lane
    logic capHi;    // store byte result in high lane
    logic capWide;  // store full word result
  } strobe_t;

  function automatic logic colorOnly(input logic [ALIAS_W-1:0] lo);
    return (lo >= 9'h040 && lo <= 9'h06B) ||
           (lo >= 9'h070 && lo <= 9'h077) ||
           (lo >= 9'h09E && lo <= 9'h09F);
  endfunction

  function automatic tgt_e classify(input logic [ADDR_W-1:0] a, input logic colorOn);
    if (a >= EEP_FIRST && a <= EEP_LAST)   return TGT_EEP;
    if (a >= CART_FIRST && a <= CART_LAST) return TGT_CART;
    if (a[ALIAS_W-1:0] > SOC_LAST)         return TGT_OPEN;
    if (!colorOn && colorOnly(a[ALIAS_W-1:0])) return TGT_OPEN;
    return TGT_SOC;
  endfunction
endpackage

// File: rtl/ioRouteData.sv
module ioRouteData
  import ioRoutePkg::*;
#(
  parameter logic [BYTE_W-1:0] OPEN_MONO  = 8'h90,
  parameter logic [BYTE_W-1:0] OPEN_COLOR = 8'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWord,
  input  logic              cpuWrite,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic              colorMode,
  input  logic [DATA_W-1:0] socRdata,
  input  logic [DATA_W-1:0] eepRdata,
  input  logic [BYTE_W-1:0] cartRdata,
  output tgt_e              cls0,
  output tgt_e              cls1,
  output logic              isWord,
  output logic              isOdd,
  output logic              isWrite,
  output logic [ADDR_W-1:0] tgtAddr,
  output logic [DATA_W-1:0] tgtWdata,
  output logic [DATA_W-1:0] cpuRdata
);
  logic [ADDR_W-1:0] addrQ, addrNext;
  logic [DATA_W-1:0] wdataQ, rdataQ, readWide;
  logic              colorQ;
  logic [BYTE_W-1:0] openByte;
  tgt_e              curCls;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      wdataQ  <= '0;
      isWord  <= 1'b0;
      isWrite <= 1'b0;
      colorQ  <= 1'b0;
      rdataQ  <= '0;
    end else if (stb.latch) begin
      addrQ   <= cpuAddr;
      wdataQ  <= cpuWdata;
      isWord  <= cpuWord;
      isWrite <= cpuWrite;
      colorQ  <= colorMode;
      rdataQ  <= '0;
    end else if (stb.capWide) begin
      rdataQ <= readWide;
    end else if (stb.capLo) begin
      rdataQ[BYTE_W-1:0] <= readWide[BYTE_W-1:0];
    end else if (stb.capHi) begin
      rdataQ[DATA_W-1:BYTE_W] <= readWide[BYTE_W-1:0];
    end
  end

  always_comb begin
    addrNext = ADDR_W'(addrQ + 1'b1);
    cls0     = classify(addrQ, colorQ);
    cls1     = classify(addrNext, colorQ);
    isOdd    = addrQ[0];
    curCls   = stb.upper ? cls1 : cls0;
    openByte = colorQ ? OPEN_COLOR : OPEN_MONO;
    tgtAddr  = stb.upper ? addrNext : addrQ;
    if (stb.wide)
      tgtWdata = wdataQ;
    else
      tgtWdata = {{(DATA_W-BYTE_W){1'b0}},
                  stb.upper ? wdataQ[DATA_W-1:BYTE_W] : wdataQ[BYTE_W-1:0]};
    case (curCls)
      TGT_SOC:  readWide = socRdata;
      TGT_EEP:  readWide = eepRdata;
      TGT_CART: readWide = {{(DATA_W-BYTE_W){1'b0}}, cartRdata};
      default:  readWide = {openByte, openByte};
    endcase
  end

  assign cpuRdata = rdataQ;
endmodule

// File: rtl/ioRouteCtrl.sv
module ioRouteCtrl
  import ioRoutePkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cpuReq,
  input  logic    cartSlow,
  input  tgt_e    cls0,
  input  tgt_e    cls1,
  input  logic    isWord,
  input  logic    isOdd,
  input  logic    isWrite,
  output strobe_t stb,
  output logic    socReq,
  output logic    eepReq,
  output logic    cartReq,
  output logic    tgtWord,
  output logic    cpuReady
);
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_GAP, ST_DONE} state_e;

  state_e stateQ;
  logic   phaseQ, waitQ;
  logic   split, wide, running, lastCyc, capture;
  tgt_e   curCls;

  always_comb begin
    split   = isWord && (isOdd ? !(cls0 == TGT_EEP && cls1 == TGT_EEP)
                               : (cls0 == TGT_CART));
    wide    = isWord && !split;
    curCls  = phaseQ ? cls1 : cls0;
    running = (stateQ == ST_RUN);
    lastCyc = (curCls != TGT_CART) || !cartSlow || waitQ;
    capture = running && lastCyc && !isWrite;

    socReq   = running && (curCls == TGT_SOC);
    eepReq   = running && (curCls == TGT_EEP);
    cartReq  = running && (curCls == TGT_CART);
    tgtWord  = running && wide;
    cpuReady = (stateQ == ST_DONE);

    stb.latch   = (stateQ == ST_IDLE) && cpuReq;
    stb.upper   = phaseQ;
    stb.wide    = wide;
    stb.capWide = capture && wide;
    stb.capLo   = capture && !wide && !phaseQ;
    stb.capHi   = capture && !wide && phaseQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      phaseQ <= 1'b0;
      waitQ  <= 1'b0;
    end else begin
      case (stateQ)
        ST_IDLE: if (cpuReq) begin
          stateQ <= ST_RUN;
          phaseQ <= 1'b0;
          waitQ  <= 1'b0;
        end
        ST_RUN: begin
          if (!lastCyc) begin
            waitQ <= 1'b1;
          end else begin
            waitQ <= 1'b0;
            if (split && !phaseQ) begin
              phaseQ <= 1'b1;
              stateQ <= isOdd ? ST_GAP : ST_RUN;
            end else begin
              stateQ <= ST_DONE;
            end
          end
        end
        ST_GAP:  stateQ <= ST_RUN;
        default: begin
          stateQ <= ST_IDLE;
          phaseQ <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/ioPortRouter.sv
module ioPortRouter
  import ioRoutePkg::*;
#(
  parameter logic [7:0] OPEN_MONO  = 8'h90,
  parameter logic [7:0] OPEN_COLOR = 8'h00
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        colorMode,
  input  logic        cartSlow,
  input  logic        cpuReq,
  input  logic [15:0] cpuAddr,
  input  logic        cpuWord,
  input  logic        cpuWrite,
  input  logic [15:0] cpuWdata,
  output logic [15:0] cpuRdata,
  output logic        cpuReady,
  output logic [15:0] tgtAddr,
  output logic [15:0] tgtWdata,
  output logic        tgtWord,
  output logic        tgtWrite,
  output logic        socReq,
  input  logic [15:0] socRdata,
  output logic        eepReq,
  input  logic [15:0] eepRdata,
  output logic        cartReq,
  input  logic [7:0]  cartRdata
);
  strobe_t stb;
  tgt_e    cls0, cls1;
  logic    isWord, isOdd, isWrite;

  ioRouteData #(.OPEN_MONO(OPEN_MONO), .OPEN_COLOR(OPEN_COLOR)) i_data (
    .clk(clk), .rstN(rstN), .stb(stb),
    .cpuAddr(cpuAddr), .cpuWord(cpuWord), .cpuWrite(cpuWrite),
    .cpuWdata(cpuWdata), .colorMode(colorMode),
    .socRdata(socRdata), .eepRdata(eepRdata), .cartRdata(cartRdata),
    .cls0(cls0), .cls1(cls1), .isWord(isWord), .isOdd(isOdd),
    .isWrite(isWrite), .tgtAddr(tgtAddr), .tgtWdata(tgtWdata),
    .cpuRdata(cpuRdata)
  );

  ioRouteCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cartSlow(cartSlow),
    .cls0(cls0), .cls1(cls1), .isWord(isWord), .isOdd(isOdd),
    .isWrite(isWrite), .stb(stb),
    .socReq(socReq), .eepReq(eepReq), .cartReq(cartReq),
    .tgtWord(tgtWord), .cpuReady(cpuReady)
  );

  assign tgtWrite = isWrite;
endmodule

// File: rtl/ioPortRouterChk.sv
module ioPortRouterChk (
  input logic        clk,
  input logic        rstN,
  input logic        colorMode,
  input logic        cartSlow,
  input logic        cpuReady,
  input logic [15:0] tgtAddr,
  input logic        tgtWord,
  input logic        socReq,
  input logic        eepReq,
  input logic        cartReq
);
  // R1: at most one target selected, and EEPROM only at its exact range
  p_one_target_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({socReq, eepReq, cartReq}));
  p_eep_range_r1: assert property (@(posedge clk) disable iff (!rstN)
    eepReq |-> (tgtAddr >= 16'h00B8 && tgtAddr <= 16'h00BF));
  // R2
  p_cart_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    cartReq |-> (tgtAddr >= 16'h00C0 && tgtAddr <= 16'h00FF));
  // R3
  p_soc_alias_r3: assert property (@(posedge clk) disable iff (!rstN)
    socReq |-> (tgtAddr[8:0] <= 9'h0B7));
  // R4
  p_color_gate_r4: assert property (@(posedge clk) disable iff (!rstN)
    (socReq && !colorMode) |->
      !((tgtAddr[8:0] >= 9'h040 && tgtAddr[8:0] <= 9'h06B) ||
        (tgtAddr[8:0] >= 9'h070 && tgtAddr[8:0] <= 9'h077) ||
        (tgtAddr[8:0] >= 9'h09E && tgtAddr[8:0] <= 9'h09F)));
  // R7
  p_cart_byte_r7: assert property (@(posedge clk) disable iff (!rstN)
    cartReq |-> !tgtWord);
  p_cart_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(cartReq) && cartSlow) |=> cartReq);
  // R11
  p_ready_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |=> !cpuReady);
  p_ready_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |-> !(socReq || eepReq || cartReq));
endmodule

bind ioPortRouter ioPortRouterChk i_chk (
  .clk(clk), .rstN(rstN), .colorMode(colorMode), .cartSlow(cartSlow),
  .cpuReady(cpuReady), .tgtAddr(tgtAddr), .tgtWord(tgtWord),
  .socReq(socReq), .eepReq(eepReq), .cartReq(cartReq)
);

// File: tb/test_ioPortRouter.sv
module test_ioPortRouter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        colorMode = 1'b0;
  logic        cartSlow = 1'b0;
  logic        cpuReq = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic        cpuWord = 1'b0;
  logic        cpuWrite = 1'b0;
  logic [15:0] cpuWdata = '0;
  logic [15:0] cpuRdata, tgtAddr, tgtWdata, socRdata, eepRdata;
  logic        cpuReady, tgtWord, tgtWrite, socReq, eepReq, cartReq;
  logic [7:0]  cartRdata;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ioPortRouter i_ioPortRouter (
    .clk(clk), .rstN(rstN), .colorMode(colorMode), .cartSlow(cartSlow),
    .cpuReq(cpuReq), .cpuAddr(cpuAddr), .cpuWord(cpuWord),
    .cpuWrite(cpuWrite), .cpuWdata(cpuWdata), .cpuRdata(cpuRdata),
    .cpuReady(cpuReady), .tgtAddr(tgtAddr), .tgtWdata(tgtWdata),
    .tgtWord(tgtWord), .tgtWrite(tgtWrite), .socReq(socReq),
    .socRdata(socRdata), .eepReq(eepReq), .eepRdata(eepRdata),
    .cartReq(cartReq), .cartRdata(cartRdata)
  );

  // target stubs: answer in the same cycle from the presented address
  assign socRdata  = {tgtAddr[7:0] + 8'h11, tgtAddr[7:0] ^ 8'h5A};
  assign eepRdata  = {tgtAddr[7:0] ^ 8'hC3, tgtAddr[7:0] + 8'h07};
  assign cartRdata = tgtAddr[7:0] ^ 8'h3C;

  typedef struct {
    int          act;   // -1 none, 0 soc, 1 eep, 2 cart
    logic [15:0] addr;
    bit          wide;
    logic [15:0] wd;
    bit          rdy;
  } cyc_t;
  cyc_t plan[$];

  function automatic int bcls(input logic [15:0] a, input bit col);
    logic [8:0] lo;
    lo = a[8:0];
    if (a >= 16'h00B8 && a <= 16'h00BF) return 1;
    if (a >= 16'h00C0 && a <= 16'h00FF) return 2;
    if (lo > 9'h0B7) return 3;
    if (!col && ((lo >= 9'h040 && lo <= 9'h06B) || (lo >= 9'h070 && lo <= 9'h077) ||
                 lo == 9'h09E || lo == 9'h09F)) return 3;
    return 0;
  endfunction

  function automatic logic [15:0] stubWord(input int t, input logic [15:0] a, input bit col);
    case (t)
      0: return {a[7:0] + 8'h11, a[7:0] ^ 8'h5A};
      1: return {a[7:0] ^ 8'hC3, a[7:0] + 8'h07};
      2: return {8'h00, a[7:0] ^ 8'h3C};
      default: return col ? 16'h0000 : 16'h9090;
    endcase
  endfunction

  task automatic pushPhase(input int t, input logic [15:0] a, input bit wide, input logic [15:0] w);
    int n;
    n = (t == 2 && cartSlow) ? 2 : 1;
    for (int i = 0; i < n; i++) plan.push_back('{(t == 3) ? -1 : t, a, wide, w, 1'b0});
  endtask

  task automatic txn(input string tag, input logic [15:0] a, input bit word,
                     input bit wr, input logic [15:0] wd);
    logic [15:0] a1, exp, v0, v1, lo8, hi8;
    int t0, t1;
    plan.delete();
    a1 = a + 16'd1;
    t0 = bcls(a, colorMode);
    t1 = bcls(a1, colorMode);
    v0 = stubWord(t0, a, colorMode);
    v1 = stubWord(t1, a1, colorMode);
    lo8 = {8'h00, wd[7:0]};
    hi8 = {8'h00, wd[15:8]};
    if (!word) begin
      pushPhase(t0, a, 0, lo8);
      exp = {8'h00, v0[7:0]};
    end else if (!a[0] && t0 != 2) begin
      pushPhase(t0, a, 1, wd);
      exp = v0;
    end else if (!a[0]) begin
      pushPhase(2, a, 0, lo8);
      pushPhase(2, a1, 0, hi8);
      exp = {v1[7:0], v0[7:0]};
    end else if (t0 == 1 && t1 == 1) begin
      pushPhase(1, a, 1, wd);
      exp = v0;
    end else begin
      pushPhase(t0, a, 0, lo8);
      plan.push_back('{-1, 16'h0, 1'b0, 16'h0, 1'b0});
      pushPhase(t1, a1, 0, hi8);
      exp = {v1[7:0], v0[7:0]};
    end
    plan.push_back('{-1, 16'h0, 1'b0, 16'h0, 1'b1});

    cpuAddr = a; cpuWord = word; cpuWrite = wr; cpuWdata = wd; cpuReq = 1'b1;
    foreach (plan[i]) begin
      cyc_t c;
      bit ok;
      c = plan[i];
      @(negedge clk);
      ok = (socReq == (c.act == 0)) && (eepReq == (c.act == 1)) &&
           (cartReq == (c.act == 2)) && (cpuReady == c.rdy);
      if (c.act >= 0)
        ok = ok && (tgtAddr == c.addr) && (tgtWord == c.wide) && (tgtWrite == wr) &&
             (!wr || tgtWdata == c.wd);
      checks++;
      if (!ok) begin
        errors++;
        $display("FAIL %s addr=%h cyc=%0d: got sel=%b%b%b rdy=%b a=%h w=%b wd=%h exp act=%0d rdy=%b a=%h w=%b wd=%h",
                 tag, a, i, socReq, eepReq, cartReq, cpuReady, tgtAddr, tgtWord, tgtWdata,
                 c.act, c.rdy, c.addr, c.wide, c.wd);
      end
      if (c.rdy) begin
        if (!wr) begin
          checks++;
          if (cpuRdata !== exp) begin
            errors++;
            $display("FAIL %s R11 read data addr=%h: got %h exp %h", tag, a, cpuRdata, exp);
          end
        end
        cpuReq = 1'b0;
      end
    end
    @(negedge clk);
    checks++;
    if (socReq || eepReq || cartReq || cpuReady) begin
      errors++;
      $display("FAIL %s idle after access: got sel=%b%b%b rdy=%b exp 0000",
               tag, socReq, eepReq, cartReq, cpuReady);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (socReq || eepReq || cartReq || cpuReady) begin // R13
      errors++;
      $display("FAIL R13 reset: got sel=%b%b%b rdy=%b exp 0000", socReq, eepReq, cartReq, cpuReady);
    end
    rstN = 1'b1;
    @(negedge clk);

    colorMode = 0; cartSlow = 0;
    txn("R1",  16'h00BA, 0, 0, 16'h0);
    txn("R6",  16'h00BC, 1, 0, 16'h0);
    txn("R6",  16'h0010, 1, 0, 16'h0);
    txn("R2",  16'h00C5, 0, 0, 16'h0);
    txn("R3",  16'hFE10, 0, 0, 16'h0);
    txn("R3",  16'h01B8, 1, 0, 16'h0);
    txn("R3",  16'hFF10, 0, 0, 16'h0);
    txn("R4",  16'h0040, 1, 0, 16'h0);
    txn("R4",  16'h029E, 0, 0, 16'h0);
    txn("R5",  16'h0100, 1, 0, 16'h0);
    txn("R9",  16'h0011, 1, 0, 16'h0);
    txn("R9",  16'h00B7, 1, 0, 16'h0);
    txn("R10", 16'h00B9, 1, 0, 16'h0);
    txn("R10", 16'h00BD, 1, 1, 16'hA55A);
    txn("R9",  16'hFFFF, 1, 0, 16'h0);
    txn("R12", 16'h0020, 1, 1, 16'h1234);
    txn("R12", 16'h0031, 1, 1, 16'hBEEF);
    txn("R8",  16'h00C2, 1, 0, 16'h0);

    cartSlow = 1;
    txn("R7",  16'h00F0, 0, 0, 16'h0);
    txn("R8",  16'h00C2, 1, 0, 16'h0);
    txn("R8",  16'h00E4, 1, 1, 16'hC0DE);
    txn("R9",  16'h00BF, 1, 0, 16'h0);
    txn("R9",  16'h00FF, 1, 1, 16'h7788);

    colorMode = 1; cartSlow = 0;
    txn("R4",  16'h0040, 1, 0, 16'h0);
    txn("R4",  16'h0470, 0, 0, 16'h0);
    txn("R5",  16'h0100, 1, 0, 16'h0);
    txn("R5",  16'h0300, 0, 1, 16'h00FF);
    txn("R9",  16'h00BF, 1, 1, 16'h5566);
    txn("R11", 16'h0055, 0, 0, 16'h0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, got hang exp completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule